// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End with Busy Polling and Step Streaming

This block is the bus-facing half of a small register-controlled peripheral. It watches a two-wire serial bus (SCL clock, open-drain SDA data) through a system clock that runs much faster than the bus. It finds START and STOP conditions, compares an 8-bit address against a fixed 4-bit type code joined with four strap pins, and moves bytes in and out with acknowledge. It hands each instruction byte and each write-data byte to a separate command controller as a one-cycle pulse. For read opcodes it shifts a zero-padded data word back to the master.

Two behaviours go beyond a plain byte slave. First, while the controller reports that a nonvolatile write is still running, the slave does not acknowledge its own address, so the master can poll until the write is done. Second, one opcode switches the slave into a streaming step mode: after that instruction is acknowledged, every SCL high pulse becomes one step pulse, with the SDA level as its direction, until STOP or a new START.

Top module: `twi_step_slave`

## Requirements
- R1: After reset, and while no START has been seen, `sda_oe_o` stays low and no event pulse appears, whatever is clocked on the bus.
- R2: A START (SDA falling while SCL high) restarts address reception from any state, including a repeated START in mid-transaction. A STOP (SDA rising while SCL high) returns the slave to idle, and `cmd_stop_o` pulses for one cycle if a transaction was open.
- R3: The first byte after START is acknowledged only if it equals `{4'b0101, dev_addr_i[3:0]}`, MSB first. On a mismatch no acknowledge is given and every later byte is ignored until the next START.
- R4: If `nv_busy_i` is high when the address byte completes, the address is not acknowledged, even when it matches.
- R5: The instruction byte that follows an acknowledged address is always acknowledged. It appears on `instr_o`, with `instr_vld_o` high for one cycle. At most one of the event pulses is high in any cycle.
- R6: For opcodes (instruction bits 7:4) other than the read and step codes, the next byte is acknowledged and presented on `data_o` with a one-cycle `data_vld_o`. Any byte after it, before STOP or START, gets no acknowledge and no pulse.
- R7: For opcodes 4'b1001 and 4'b1011 the slave drives eight bits after the instruction acknowledge: two zeros, then `rd_data_i[5:0]`, MSB first. It then releases SDA for the master's acknowledge.
- R8: For opcode 4'b0010, each complete SCL high pulse after the instruction acknowledge gives one `step_o` pulse at the SCL fall. `step_up_o` is the SDA level at the SCL rise (1 = up, 0 = down). The SCL rise of a STOP or START produces no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| dev_addr_i | input | 4 | Strap value for the low address nibble |
| nv_busy_i | input | 1 | Nonvolatile write in progress |
| rd_data_i | input | 6 | Word returned by read opcodes |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| instr_o | output | 8 | Last instruction byte |
| instr_vld_o | output | 1 | One-cycle pulse: instruction received |
| data_o | output | 8 | Last write-data byte |
| data_vld_o | output | 1 | One-cycle pulse: data byte received |
| step_o | output | 1 | One-cycle step pulse |
| step_up_o | output | 1 | Direction of the latest step |
| cmd_stop_o | output | 1 | One-cycle pulse: STOP closed a transaction |

## Verification
The bench clocks a full address byte before any START. A slave that armed itself on plain bit activity would acknowledge it. It sends a wrong address, then more bytes without a new START, which exposes a slave that keeps listening after a mismatch. It polls with the busy flag raised, and a slave that ignored busy would acknowledge. In step mode it ends the stream with a STOP and, in a second run, with a repeated START. A slave that stepped on SCL rises instead of completed pulses would leave an extra step in the scoreboard. A slave that dropped the two zero pad bits would return a shifted read word.

// File: rtl/twi_step_slave.sv
module twi_step_slave #(
  parameter logic [3:0] ID       = 4'b0101,
  parameter logic [3:0] OP_STEP  = 4'b0010,
  parameter logic [3:0] OP_RDREG = 4'b1001,
  parameter logic [3:0] OP_RDDAT = 4'b1011,
  parameter int         DW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [3:0]    dev_addr_i,
  input  logic          nv_busy_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic [7:0]    instr_o,
  output logic          instr_vld_o,
  output logic [7:0]    data_o,
  output logic          data_vld_o,
  output logic          step_o,
  output logic          step_up_o,
  output logic          cmd_stop_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ, S_STEP, S_WAIT
  } st_t;

  st_t        state, nxt;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt;
  logic       in_ack, oe, step_dir;
  logic [7:0] sh, tx;

  wire scl_s = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_d = sda_q[2];

  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire active   = (state != S_IDLE) && (state != S_WAIT);
  wire [7:0] txv = 8'(rd_data_i);
  wire is_rd    = (sh[7:4] == OP_RDREG) || (sh[7:4] == OP_RDDAT);

  assign sda_oe_o = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      nxt         <= S_IDLE;
      cnt         <= '0;
      in_ack      <= 1'b0;
      oe          <= 1'b0;
      sh          <= '0;
      tx          <= '0;
      step_dir    <= 1'b0;
      instr_o     <= '0;
      data_o      <= '0;
      instr_vld_o <= 1'b0;
      data_vld_o  <= 1'b0;
      step_o      <= 1'b0;
      step_up_o   <= 1'b0;
      cmd_stop_o  <= 1'b0;
    end else begin
      instr_vld_o <= 1'b0;
      data_vld_o  <= 1'b0;
      step_o      <= 1'b0;
      cmd_stop_o  <= 1'b0;
      if (start_c) begin
        state  <= S_ADDR;
        cnt    <= '0;
        in_ack <= 1'b0;
        oe     <= 1'b0;
      end else if (stop_c) begin
        if (state != S_IDLE) cmd_stop_o <= 1'b1;
        state  <= S_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        oe     <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (state == S_STEP) step_dir <= sda_s;
          else if (!in_ack && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
        end
        if (scl_fall) begin
          if (state == S_STEP) begin
            step_o    <= 1'b1;
            step_up_o <= step_dir;
          end else if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            state  <= nxt;
            if (nxt == S_READ) begin
              oe <= ~txv[7];
              tx <= {txv[6:0], 1'b0};
            end else begin
              oe <= 1'b0;
            end
          end else if (cnt == 4'd8) begin
            in_ack <= 1'b1;
            case (state)
              S_ADDR: begin
                if (sh == {ID, dev_addr_i} && !nv_busy_i) begin
                  oe  <= 1'b1;
                  nxt <= S_INSTR;
                end else begin
                  oe  <= 1'b0;
                  nxt <= S_IDLE;
                end
              end
              S_INSTR: begin
                oe          <= 1'b1;
                instr_o     <= sh;
                instr_vld_o <= 1'b1;
                nxt <= (sh[7:4] == OP_STEP) ? S_STEP : (is_rd ? S_READ : S_DATA);
              end
              S_DATA: begin
                oe         <= 1'b1;
                data_o     <= sh;
                data_vld_o <= 1'b1;
                nxt        <= S_WAIT;
              end
              default: begin
                oe  <= 1'b0;
                nxt <= S_WAIT;
              end
            endcase
          end else if (state == S_READ) begin
            oe <= ~tx[7];
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

module twi_step_slave_chk #(
  parameter logic [3:0] ID = 4'b0101,
  parameter int         DW = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic [3:0] cnt,
  input logic       in_ack,
  input logic [7:0] sh,
  input logic [3:0] dev_addr,
  input logic       nv_busy,
  input logic       sda_oe,
  input logic       instr_vld,
  input logic       data_vld,
  input logic       step,
  input logic       cmd_stop
);
  localparam logic [2:0] C_IDLE = 3'd0, C_ADDR = 3'd1, C_DATA = 3'd3,
                         C_READ = 3'd4, C_STEP = 3'd5;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == C_IDLE |-> !sda_oe); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |-> state == C_IDLE); // R2
  AST_ADDR_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state == C_ADDR) |-> $past(sh) == {ID, dev_addr}); // R3
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state == C_ADDR) |-> !$past(nv_busy)); // R4
  AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_vld, data_vld, step, cmd_stop})); // R5
  AST_DATA_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |-> state == C_DATA); // R6
  AST_READ_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (DW <= 6 && state == C_READ && !in_ack && cnt < 4'd2) |-> sda_oe); // R7
  AST_STEP_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> state == C_STEP); // R8
endmodule

bind twi_step_slave twi_step_slave_chk #(.ID(ID), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .in_ack(in_ack),
  .sh(sh), .dev_addr(dev_addr_i), .nv_busy(nv_busy_i), .sda_oe(sda_oe_o),
  .instr_vld(instr_vld_o), .data_vld(data_vld_o), .step(step_o),
  .cmd_stop(cmd_stop_o)
);

// File: tb/twi_step_slave_tb.sv
`timescale 1ns/1ps
module twi_step_slave_tb_top;
  localparam int Q = 10;
  localparam logic [1:0] K_INSTR = 2'd0, K_DATA = 2'd1, K_STEP = 2'd2, K_STOP = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, nv_busy = 1'b0;
  logic [3:0] dev = 4'hA;
  logic [5:0] rd = 6'h00;
  logic oe, ivld, dvld, stp, stp_up, cstop;
  logic [7:0] instr, data;
  wire sda = ~(m_low | oe);

  typedef struct packed { logic [1:0] k; logic [7:0] v; } item_t;
  item_t expq[$];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  twi_step_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .dev_addr_i(dev),
    .nv_busy_i(nv_busy), .rd_data_i(rd), .sda_oe_o(oe), .instr_o(instr),
    .instr_vld_o(ivld), .data_o(data), .data_vld_o(dvld), .step_o(stp),
    .step_up_o(stp_up), .cmd_stop_o(cstop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] v);
    expq.push_back('{k: k, v: v});
  endtask

  task automatic tick(input bit b, output bit r);
    m_low = !b; wq(Q); scl = 1'b1; wq(Q); r = sda; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) tick(b[i], r);
    tick(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit r;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(1'b1, r);
      b = {b[6:0], r};
    end
    tick(!mack, r);
  endtask

  task automatic step_tick(input bit d);
    push(K_STEP, {7'd0, d});
    m_low = !d; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (ivld || dvld || stp || cstop)) begin
      item_t got, want;
      string req;
      got.k = ivld ? K_INSTR : dvld ? K_DATA : stp ? K_STEP : K_STOP;
      got.v = ivld ? instr : dvld ? data : stp ? {7'd0, stp_up} : 8'd0;
      req = (got.k == K_INSTR) ? "R5 instr event" : (got.k == K_DATA) ? "R6 data event" :
            (got.k == K_STEP) ? "R8 step event" : "R2 stop event";
      if (expq.size() == 0) begin
        chk(1'b0, {req, " unexpected"}, int'(got), -1);
      end else begin
        want = expq.pop_front();
        chk(got == want, req, int'(got), int'(want));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    wq(5);
    chk(oe == 1'b0, "R1 reset oe", oe, 0);
    rst_n = 1'b1; wq(5);

    // R1: activity before any START
    scl = 1'b0; wq(Q);
    send_byte(8'h5A, ack);
    chk(!ack, "R1 ack before START", ack, 0);

    // write instruction with one data byte
    bus_start();
    send_byte(8'h5A, ack); chk(ack, "R3 address ack", ack, 1);
    push(K_INSTR, 8'hA0);
    send_byte(8'hA0, ack); chk(ack, "R5 instr ack", ack, 1);
    push(K_DATA, 8'h2A);
    send_byte(8'h2A, ack); chk(ack, "R6 data ack", ack, 1);
    send_byte(8'h55, ack); chk(!ack, "R6 extra byte nack", ack, 0);
    push(K_STOP, 8'h00);
    bus_stop();

    // wrong pin bits, then bytes without START
    bus_start();
    send_byte(8'h5B, ack); chk(!ack, "R3 pin mismatch nack", ack, 0);
    send_byte(8'hA0, ack); chk(!ack, "R3 ignored until START", ack, 0);
    bus_stop();

    // wrong type nibble
    bus_start();
    send_byte(8'h7A, ack); chk(!ack, "R3 type mismatch nack", ack, 0);
    bus_stop();

    // busy polling
    nv_busy = 1'b1;
    bus_start();
    send_byte(8'h5A, ack); chk(!ack, "R4 busy nack", ack, 0);
    bus_stop();
    nv_busy = 1'b0;
    bus_start();
    send_byte(8'h5A, ack); chk(ack, "R4 ack after busy clears", ack, 1);
    push(K_INSTR, 8'h8C);
    send_byte(8'h8C, ack); chk(ack, "R5 two-byte instr ack", ack, 1);
    push(K_STOP, 8'h00);
    bus_stop();

    // reads
    rd = 6'h2D;
    bus_start();
    send_byte(8'h5A, ack);
    push(K_INSTR, 8'h91);
    send_byte(8'h91, ack); chk(ack, "R7 read instr ack", ack, 1);
    recv_byte(1'b0, b); chk(b == 8'h2D, "R7 read word", b, 8'h2D);
    push(K_STOP, 8'h00);
    bus_stop();

    rd = 6'h3F;
    bus_start();
    send_byte(8'h5A, ack);
    push(K_INSTR, 8'hB6);
    send_byte(8'hB6, ack);
    recv_byte(1'b0, b); chk(b == 8'h3F, "R7 read pad bits", b, 8'h3F);
    push(K_STOP, 8'h00);
    bus_stop();

    rd = 6'h20;
    bus_start();
    send_byte(8'h5A, ack);
    push(K_INSTR, 8'h93);
    send_byte(8'h93, ack);
    recv_byte(1'b0, b); chk(b == 8'h20, "R7 read msb", b, 8'h20);
    push(K_STOP, 8'h00);
    bus_stop();

    // step streaming ended by STOP
    bus_start();
    send_byte(8'h5A, ack);
    push(K_INSTR, 8'h21);
    send_byte(8'h21, ack); chk(ack, "R8 step instr ack", ack, 1);
    step_tick(1'b1); step_tick(1'b1); step_tick(1'b0);
    step_tick(1'b1); step_tick(1'b0); step_tick(1'b0);
    push(K_STOP, 8'h00);
    bus_stop();

    // step streaming ended by repeated START
    bus_start();
    send_byte(8'h5A, ack);
    push(K_INSTR, 8'h20);
    send_byte(8'h20, ack);
    step_tick(1'b1);
    bus_start();
    send_byte(8'h5A, ack); chk(ack, "R2 repeated START address ack", ack, 1);
    push(K_INSTR, 8'hC4);
    send_byte(8'hC4, ack); chk(ack, "R2 instr after repeated START", ack, 1);
    push(K_STOP, 8'h00);
    bus_stop();

    wq(50);
    chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
    chk(oe == 1'b0, "R1 released at end", oe, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule